// File: doc/BRIEF.md
# Strobed Parallel Port

This block is a bus-attached parallel I/O unit. It offers three 8-bit ports (A, B and C) and a configuration register. All four sit on an 8-bit processor data bus that has separate inbound and outbound lanes and a drive-enable flag. A 2-bit address picks the target. An access takes place only while the select input is high together with exactly one of read or write. The configuration register sets the direction of port A, port B and each half of port C. Every port pin group has an output value and an output-enable, so a pad ring can build the physical bidirectional lines.

A handshake mode turns port A into a strobed input, such as a keyboard would use. A rising edge on a data-ready line, carried on port C, captures port A into a holding register. The same edge raises an interrupt request on another port C line. When the processor reads port A, the request clears and a one-cycle acknowledge pulse tells the peripheral it may replace its data. The port C lines not used by the handshake stay general-purpose I/O.

Top module: `parPortHs`

## Requirements
- R1: Address 2'b00 selects port A, 2'b01 port B, 2'b10 port C and 2'b11 the configuration register, which reads back its stored value.
- R2: A write happens only when `sel` and `wrEn` are high and `rdEn` is low. A read happens only when `sel` and `rdEn` are high and `wrEn` is low. With both strobes high, or `sel` low, nothing is changed or driven.
- R3: `busDrive` is high and `busOut` carries data only during a selected read; at all other times `busDrive` is 0 and `busOut` is 0.
- R4: Configuration bits: bit0=1 makes port A an input, bit1=1 port B, bit2=1 port C bits 3:0, bit3=1 port C bits 7:4; bit4=1 enables handshake mode. The reset value is 8'h0F. `paOe`, `pbOe` and `pcOe` are high exactly for output lines.
- R5: A write to the configuration register clears the output registers of all three ports, the port A capture register, the interrupt request and the acknowledge, in the cycle after the write.
- R6: A write to a port, or a port C half, that is set as input has no effect on its output pins.
- R7: A read of an input port returns its live pins; a read of an output port returns the last written value, which also appears on its output pins from the cycle after the write.
- R8: In handshake mode port A is an input regardless of bit0. A rising edge on `pcIn[4]` (data ready) captures `paIn`, and from the next cycle `pcOut[3]` (interrupt request) is 1 and a port A read returns the captured byte.
- R9: In handshake mode a port A read clears the interrupt request from the next cycle. `pcOut[5]` (acknowledge) is 1 for exactly the one cycle after the read.
- R10: When a ready edge and a port A read fall in the same cycle, the read returns the previously captured byte, the new byte is captured, the interrupt request stays 1 and the acknowledge still pulses.
- R11: In handshake mode `pcOe` has bits 3 and 5 high and bit 4 low, whatever the half settings. A port C read returns the interrupt request at bit 3, the acknowledge at bit 5 and the ready pin at bit 4.
- R12: After reset all output pins are 0, all ports are inputs and no interrupt request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 2 | Port / configuration select |
| busIn | input | 8 | Write data from processor |
| busOut | output | 8 | Read data to processor |
| busDrive | output | 1 | High while the block drives the data bus |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A output values |
| paOe | output | 1 | Port A output enable |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B output values |
| pbOe | output | 1 | Port B output enable |
| pcIn | input | 8 | Port C pin inputs (bit 4 data ready in handshake mode) |
| pcOut | output | 8 | Port C output values (bit 3 interrupt, bit 5 acknowledge in handshake mode) |
| pcOe | output | 8 | Port C per-bit output enable |

## Verification
The capture of a new byte on a data-ready edge and the processor's read of port A can land in the same clock cycle. The read then has to return the old byte while the register takes the new one, and the set of the interrupt request has to win over its clear. The bench provokes this by raising the ready line in the very cycle its port A read is on the bus. It judges the result in three ways: the scoreboard compares the returned byte, the pins show the request still high alongside the acknowledge pulse, and a later read returns the newly captured byte.

// File: rtl/parPortPkg.sv
package parPortPkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CFG = 2'b11
  } portSelT;

  // configuration bit positions
  localparam int CFG_A_IN   = 0;
  localparam int CFG_B_IN   = 1;
  localparam int CFG_CLO_IN = 2;
  localparam int CFG_CHI_IN = 3;
  localparam int CFG_HS     = 4;

  // port C lines claimed by the handshake
  localparam int HS_IRQ_BIT = 3;
  localparam int HS_RDY_BIT = 4;
  localparam int HS_ACK_BIT = 5;

  typedef struct packed {
    logic    wrA;
    logic    wrB;
    logic    wrC;
    logic    clrOuts;
    logic    capA;
    logic    rdOn;
    portSelT rdSel;
    logic    irq;
    logic    ack;
    logic    hsOn;
    logic    aIn;
    logic    bIn;
    logic    cLoIn;
    logic    cHiIn;
  } ppStrobeT;

endpackage

// File: rtl/parPortCtrl.sv
module parPortCtrl
  import parPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdyIn,
  output ppStrobeT          stb,
  output logic [DATA_W-1:0] cfgVal
);

  localparam logic [DATA_W-1:0] CFG_RST = DATA_W'(15);

  logic [DATA_W-1:0] cfgReg;
  logic              irqReg;
  logic              ackReg;
  logic              rdyPrev;
  logic              wrAcc;
  logic              rdAcc;
  logic              cfgWr;
  logic              hsOn;
  logic              aIn;
  logic              rdyEdge;
  logic              rdA;
  portSelT           accSel;

  assign accSel  = portSelT'(addr);
  assign wrAcc   = sel & wrEn & ~rdEn;
  assign rdAcc   = sel & rdEn & ~wrEn;
  assign cfgWr   = wrAcc & (accSel == SEL_CFG);
  assign hsOn    = cfgReg[CFG_HS];
  assign aIn     = cfgReg[CFG_A_IN] | hsOn;
  assign rdyEdge = hsOn & rdyIn & ~rdyPrev;
  assign rdA     = rdAcc & (accSel == SEL_A) & hsOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg  <= CFG_RST;
      irqReg  <= 1'b0;
      ackReg  <= 1'b0;
      rdyPrev <= 1'b0;
    end else begin
      rdyPrev <= rdyIn;
      if (cfgWr) begin
        cfgReg <= wrData;
        irqReg <= 1'b0;
        ackReg <= 1'b0;
      end else begin
        ackReg <= rdA;
        if (rdyEdge) begin
          irqReg <= 1'b1;
        end else if (rdA) begin
          irqReg <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    stb.wrA     = wrAcc & (accSel == SEL_A) & ~aIn;
    stb.wrB     = wrAcc & (accSel == SEL_B) & ~cfgReg[CFG_B_IN];
    stb.wrC     = wrAcc & (accSel == SEL_C);
    stb.clrOuts = cfgWr;
    stb.capA    = rdyEdge;
    stb.rdOn    = rdAcc;
    stb.rdSel   = accSel;
    stb.irq     = irqReg;
    stb.ack     = ackReg;
    stb.hsOn    = hsOn;
    stb.aIn     = aIn;
    stb.bIn     = cfgReg[CFG_B_IN];
    stb.cLoIn   = cfgReg[CFG_CLO_IN];
    stb.cHiIn   = cfgReg[CFG_CHI_IN];
  end

  assign cfgVal = cfgReg;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rdyEdge && !cfgWr) |=> irqReg) else $error("irq not set"); // R8

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rdA && !rdyEdge && !cfgWr) |=> !irqReg) else $error("irq not cleared"); // R9

  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackReg) |-> $past(rdA)) else $error("ack without read"); // R9

  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdA && rdyEdge && !cfgWr) |=> (irqReg && ackReg)) else $error("collision lost"); // R10

endmodule

// File: rtl/parPortData.sv
module parPortData
  import parPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ppStrobeT          stb,
  input  logic [DATA_W-1:0] cfgVal,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] paIn,
  input  logic [DATA_W-1:0] pbIn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] paOut,
  output logic              paOe,
  output logic [DATA_W-1:0] pbOut,
  output logic              pbOe,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pcOe
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] paReg;
  logic [DATA_W-1:0] pbReg;
  logic [DATA_W-1:0] pcReg;
  logic [DATA_W-1:0] paLatch;
  logic [DATA_W-1:0] pcWrMask;
  logic [DATA_W-1:0] pcRd;
  logic [DATA_W-1:0] muxVal;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pcBit
    localparam bit IS_HS  = (i == HS_IRQ_BIT) || (i == HS_RDY_BIT) || (i == HS_ACK_BIT);
    localparam bit IS_LOW = (i < HALF);
    localparam bit IS_IRQ = (i == HS_IRQ_BIT);
    localparam bit IS_ACK = (i == HS_ACK_BIT);
    localparam bit IS_RDY = (i == HS_RDY_BIT);
    logic halfOut;
    logic hsOwn;
    assign halfOut     = IS_LOW ? ~stb.cLoIn : ~stb.cHiIn;
    assign hsOwn       = stb.hsOn & IS_HS;
    assign pcWrMask[i] = halfOut & ~hsOwn;
    assign pcOe[i]     = hsOwn ? ~IS_RDY : halfOut;
    assign pcOut[i]    = (hsOwn && IS_IRQ) ? stb.irq :
                         (hsOwn && IS_ACK) ? stb.ack : pcReg[i];
    assign pcRd[i]     = (hsOwn && IS_IRQ) ? stb.irq :
                         (hsOwn && IS_ACK) ? stb.ack :
                         (hsOwn && IS_RDY) ? pcIn[i] :
                         halfOut ? pcReg[i] : pcIn[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paReg   <= '0;
      pbReg   <= '0;
      pcReg   <= '0;
      paLatch <= '0;
    end else if (stb.clrOuts) begin
      paReg   <= '0;
      pbReg   <= '0;
      pcReg   <= '0;
      paLatch <= '0;
    end else begin
      if (stb.wrA)  paReg   <= wrData;
      if (stb.wrB)  pbReg   <= wrData;
      if (stb.wrC)  pcReg   <= (pcReg & ~pcWrMask) | (wrData & pcWrMask);
      if (stb.capA) paLatch <= paIn;
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_A:   muxVal = stb.hsOn ? paLatch : (stb.aIn ? paIn : paReg);
      SEL_B:   muxVal = stb.bIn ? pbIn : pbReg;
      SEL_C:   muxVal = pcRd;
      default: muxVal = cfgVal;
    endcase
  end

  assign rdData = stb.rdOn ? muxVal : '0;
  assign paOut  = paReg;
  assign pbOut  = pbReg;
  assign paOe   = ~stb.aIn;
  assign pbOe   = ~stb.bIn;

  AST_CLR_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrOuts |=> (paReg == '0 && pbReg == '0 && pcReg == '0 && paLatch == '0))
    else $error("outputs not cleared"); // R5

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.capA && !stb.clrOuts) |=> (paLatch == $past(paIn))) else $error("capture lost"); // R8

endmodule

// File: rtl/parPortHs.sv
module parPortHs
  import parPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  input  logic [DATA_W-1:0] paIn,
  output logic [DATA_W-1:0] paOut,
  output logic              paOe,
  input  logic [DATA_W-1:0] pbIn,
  output logic [DATA_W-1:0] pbOut,
  output logic              pbOe,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pcOe
);

  ppStrobeT          stb;
  logic [DATA_W-1:0] cfgVal;

  parPortCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (busIn),
    .rdyIn  (pcIn[HS_RDY_BIT]),
    .stb    (stb),
    .cfgVal (cfgVal)
  );

  parPortData #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .cfgVal (cfgVal),
    .wrData (busIn),
    .paIn   (paIn),
    .pbIn   (pbIn),
    .pcIn   (pcIn),
    .rdData (busOut),
    .paOut  (paOut),
    .paOe   (paOe),
    .pbOut  (pbOut),
    .pbOe   (pbOe),
    .pcOut  (pcOut),
    .pcOe   (pcOe)
  );

  assign busDrive = stb.rdOn;

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rdEn && !wrEn) |-> (!busDrive && busOut == '0)) else $error("bus driven"); // R3

  AST_IN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wrEn && !rdEn && addr == 2'b00 && !paOe) |=> $stable(paOut))
    else $error("input port written"); // R6

  AST_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wrEn && rdEn && addr != 2'b11) |=> ($stable(paOut) && $stable(pbOut)))
    else $error("dual strobe wrote"); // R2

endmodule

// File: tb/parPortHs_tb.sv
module parPortHs_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic       busDrive;
  logic [7:0] paIn = 8'h00;
  logic [7:0] paOut;
  logic       paOe;
  logic [7:0] pbIn = 8'h00;
  logic [7:0] pbOut;
  logic       pbOe;
  logic [7:0] pcIn = 8'h00;
  logic [7:0] pcOut;
  logic [7:0] pcOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  event       rdEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  parPortHs u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .busIn(busIn), .busOut(busOut), .busDrive(busDrive),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the driver announces a read
  initial begin
    forever begin
      @(rdEv);
      #1;
      if (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " busDrive"}, {7'd0, busDrive}, 8'h01);
        chk(t, busOut, e);
      end
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; rdEn = 1'b0; addr = a; busIn = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [7:0] e, input string t,
                         input bit strobe);
    @(negedge clk);
    sel = 1'b1; rdEn = 1'b1; wrEn = 1'b0; addr = a;
    if (strobe) pcIn[4] = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(t);
    ->rdEv;
    #2;
    @(negedge clk);
    sel = 1'b0; rdEn = 1'b0;
  endtask

  task automatic strobeA(input logic [7:0] d);
    @(negedge clk);
    pcIn[4] = 1'b0; paIn = d;
    @(negedge clk);
    pcIn[4] = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state, R4 reset directions, R3 quiet bus
    chk("R12 paOut", paOut, 8'h00);
    chk("R12 pbOut", pbOut, 8'h00);
    chk("R12 pcOut", pcOut, 8'h00);
    chk("R4 oe reset", {6'd0, paOe, pbOe}, 8'h00);
    chk("R4 pcOe reset", pcOe, 8'h00);
    chk("R3 idle bus", busOut, 8'h00);
    chk("R3 idle drive", {7'd0, busDrive}, 8'h00);
    busRead(2'b11, 8'h0F, "R1 R4 cfg reset read", 1'b0);

    // R7 input ports read live pins
    paIn = 8'hA5; pbIn = 8'h3C; pcIn = 8'h86;
    busRead(2'b00, 8'hA5, "R7 R1 read A input", 1'b0);
    busRead(2'b01, 8'h3C, "R7 R1 read B input", 1'b0);
    busRead(2'b10, 8'h86, "R7 R1 read C input", 1'b0);

    // R6 write to input port ignored
    busWrite(2'b00, 8'h55);
    chk("R6 paOut after input write", paOut, 8'h00);

    // all outputs
    busWrite(2'b11, 8'h00);
    chk("R4 outputs oe", {6'd0, paOe, pbOe}, 8'h03);
    chk("R4 pcOe all out", pcOe, 8'hFF);
    busWrite(2'b00, 8'h11);
    chk("R7 paOut", paOut, 8'h11);
    busWrite(2'b01, 8'h22);
    chk("R7 pbOut", pbOut, 8'h22);
    busWrite(2'b10, 8'h33);
    chk("R7 pcOut", pcOut, 8'h33);
    busRead(2'b00, 8'h11, "R7 readback A", 1'b0);
    busRead(2'b01, 8'h22, "R7 readback B", 1'b0);
    busRead(2'b10, 8'h33, "R7 readback C", 1'b0);
    busRead(2'b11, 8'h00, "R1 cfg readback", 1'b0);

    // R2 dual strobe and unselected write ignored
    @(negedge clk);
    sel = 1'b1; rdEn = 1'b1; wrEn = 1'b1; addr = 2'b00; busIn = 8'h77;
    #1;
    chk("R2 R3 dual strobe no drive", {7'd0, busDrive}, 8'h00);
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b1; rdEn = 1'b0; busIn = 8'h66;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R2 paOut unchanged", paOut, 8'h11);

    // R5 cfg write clears outputs; C lower input
    busWrite(2'b11, 8'h04);
    chk("R5 paOut cleared", paOut, 8'h00);
    chk("R5 pbOut cleared", pbOut, 8'h00);
    chk("R5 pcOut cleared", pcOut, 8'h00);
    chk("R4 pcOe upper only", pcOe, 8'hF0);
    busWrite(2'b10, 8'hAB);
    chk("R6 pcOut upper half only", pcOut, 8'hA0);
    busRead(2'b10, 8'hA6, "R7 mixed C read", 1'b0);

    // handshake mode
    pcIn = 8'h00;
    busWrite(2'b11, 8'h10);
    chk("R8 paOe forced input", {7'd0, paOe}, 8'h00);
    chk("R11 pcOe in handshake", pcOe, 8'hEF);
    chk("R11 pcOut idle", pcOut, 8'h00);
    strobeA(8'h5A);
    chk("R8 irq raised", {7'd0, pcOut[3]}, 8'h01);
    paIn = 8'hFF;
    busRead(2'b10, 8'h18, "R11 read C status", 1'b0);
    busRead(2'b00, 8'h5A, "R8 read captured A", 1'b0);
    chk("R9 irq cleared", {7'd0, pcOut[3]}, 8'h00);
    chk("R9 ack high", {7'd0, pcOut[5]}, 8'h01);
    @(negedge clk);
    chk("R9 ack one cycle", {7'd0, pcOut[5]}, 8'h00);

    // R10 collision: strobe and read in same cycle
    strobeA(8'h21);
    pcIn[4] = 1'b0;
    paIn = 8'h42;
    @(negedge clk);
    busRead(2'b00, 8'h21, "R10 read old byte", 1'b1);
    chk("R10 irq kept", {7'd0, pcOut[3]}, 8'h01);
    chk("R10 ack pulsed", {7'd0, pcOut[5]}, 8'h01);
    busRead(2'b00, 8'h42, "R10 new byte captured", 1'b0);

    // R5 with pending interrupt
    strobeA(8'h77);
    chk("R8 irq raised again", {7'd0, pcOut[3]}, 8'h01);
    busWrite(2'b11, 8'h10);
    chk("R5 irq cleared by cfg", pcOut, 8'h00);
    busRead(2'b00, 8'h00, "R5 capture cleared", 1'b0);

    repeat (2) @(negedge clk);
    finish();
  end

endmodule